// File: doc/BRIEF.md
# Bulk IN Endpoint Transmit Controller

This block runs the transmit side of one bulk IN endpoint on a full-speed USB device. Software pushes packet bytes into a transmit FIFO and drives an 8-bit control/status register. A packet engine reports each IN token. The block answers with a one-cycle reply: NAK, DATA (with a packet length) or STALL. After a DATA reply it hands over bytes on request and marks the last one. It then waits for the engine to report whether the host acknowledged the packet. Bytes leave the FIFO for good only on an acknowledge. Without one, the read position rewinds and the same packet goes out on the next token.

The control/status register mixes four kinds of bits:
- read-only status;
- write-1-to-clear event flags;
- write-1-to-set requests;
- one plain read/write bit.

Software can arm a short (or zero-length) packet, force STALL replies, flush the FIFO, and see whether a whole maximum-size packet still fits. A state machine orders the work through these states:
- IDLE (waiting for a token);
- REPLY_DATA, REPLY_NAK and REPLY_STALL (each one cycle, with the reply pulse);
- SEND (handing out bytes);
- WAIT_HS (waiting for the handshake result).

Its transitions are:
- IDLE to one of the three reply states on a token;
- REPLY_DATA to SEND when the length is non-zero, or to WAIT_HS when it is zero;
- REPLY_NAK and REPLY_STALL back to IDLE;
- SEND to WAIT_HS on the request for the final byte;
- WAIT_HS to IDLE when the handshake report arrives.

Top module: `bulk_in_ep`

## Requirements
- R1: After reset the register reads 0x01 (room set, every other bit 0), no reply is pending and the FIFO is empty.
- R2: Register layout:
  - bit0 room (read-only);
  - bit1 sent-OK (write 1 to clear);
  - bit2 underrun (write 1 to clear);
  - bit3 STALL-sent (write 1 to clear);
  - bit4 force-STALL (read/write);
  - bit5 flush (write 1 to act);
  - bit6 short-armed (write 1 to set);
  - bit7 unused.
  
  Bits 5 and 7 always read 0, and writes to bit0 have no effect.
- R3: A token in IDLE produces `resp_valid` for exactly one cycle, in the cycle after the token is sampled. `resp_kind` is 00 for NAK, 01 for DATA and 10 for STALL. When at least 64 unsent bytes are stored and STALL is not forced, the reply is DATA with length 64.
- R4: With fewer than 64 bytes stored and short-armed set, the reply is DATA with length equal to the stored count, which may be 0. Short-armed clears when that short packet is acknowledged, and not when a full packet is acknowledged.
- R5: With STALL not forced, fewer than 64 bytes stored and short-armed clear, a token gets NAK.
- R6: While force-STALL is 1, every token gets STALL, even when a full packet is stored. STALL-sent becomes 1 after each STALL reply and stays 1 until software writes 1 to it.
- R7: In SEND, each `byte_req` takes the byte shown on `tx_byte`; bytes leave in write order. `tx_last` is 1 while the final byte of the packet is shown.
- R8: An acknowledged handshake frees the packet's bytes and sets sent-OK (write 1 to clear). A handshake without acknowledge keeps the bytes, so the next DATA reply starts again at the same first byte.
- R9: A `byte_req` in SEND with the FIFO empty sets underrun and `tx_byte` reads 0; underrun clears on write 1.
- R10: Writing 1 to bit5 empties the FIFO at once. Room (bit0) reads 1 exactly when free slots are at least 64, out of a depth of 128.
- R11: A byte written while 128 bytes are stored is dropped.
- R12: Tokens that arrive outside IDLE produce no reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| fifo_we | input | 1 | FIFO byte write strobe |
| fifo_wdata | input | 8 | FIFO byte to store |
| tok_in | input | 1 | IN token seen by the packet engine |
| resp_valid | output | 1 | One-cycle reply pulse |
| resp_kind | output | 2 | Reply type: 00 NAK, 01 DATA, 10 STALL |
| pkt_len | output | 7 | Length of the DATA packet |
| byte_req | input | 1 | Engine takes the current byte |
| tx_byte | output | 8 | Byte offered to the engine |
| tx_last | output | 1 | Offered byte is the packet's last |
| hs_valid | input | 1 | Handshake result reported |
| hs_ack | input | 1 | Host acknowledged the packet |

## Verification
The bench pushes more than one packet of bytes and refuses the first handshake. A design that freed bytes on the send rather than on the acknowledge would resend the wrong first byte.

It arms a short packet with the FIFO flushed, so a zero-length reply must go straight to the handshake wait. A design that entered SEND there would hang or report a spurious underrun.

It forces STALL while a full packet waits, catching a priority order that sends data. It flushes in the middle of a packet, which must raise underrun and present zero bytes.

It overfills the FIFO and sends tokens in the middle of SEND. A dropped-byte count that is off, or a second reply during a packet, shows up as an extra DATA reply or a miscompared byte.

// File: rtl/inep_pkg.sv
package inep_pkg;
    typedef enum logic [1:0] {
        HS_NAK   = 2'b00,
        HS_DATA  = 2'b01,
        HS_STALL = 2'b10
    } hs_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REPLY_DATA,
        ST_REPLY_NAK,
        ST_REPLY_STALL,
        ST_SEND,
        ST_WAIT_HS
    } ep_state_e;

    localparam int B_ROOM   = 0;
    localparam int B_DONE   = 1;
    localparam int B_URUN   = 2;
    localparam int B_SSENT  = 3;
    localparam int B_SFORCE = 4;
    localparam int B_FLUSH  = 5;
    localparam int B_SHORT  = 6;
endpackage

// File: rtl/inep_fifo.sv
// Transmit FIFO with a speculative read pointer and a commit pointer.
module inep_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          flush,
    input  logic          commit,
    input  logic          rewind,
    output logic [DW-1:0] head,
    output logic [PW-1:0] unread,
    output logic [PW-1:0] stored,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q, cm_q;

    assign stored = wr_q - cm_q;
    assign unread = wr_q - rd_q;
    assign empty  = (unread == '0);
    assign full   = (stored == PW'(DEPTH));
    assign head   = mem[rd_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full && !flush) begin
            mem[wr_q[AW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
            cm_q <= '0;
        end else if (flush) begin
            wr_q <= '0;
            rd_q <= '0;
            cm_q <= '0;
        end else begin
            if (push && !full) begin
                wr_q <= wr_q + 1'b1;
            end
            if (rewind) begin
                rd_q <= cm_q;
            end else if (pop && !empty) begin
                rd_q <= rd_q + 1'b1;
            end
            if (commit) begin
                cm_q <= rd_q;
            end
        end
    end
endmodule

// File: rtl/inep_csr.sv
// Control/status register: mixed read-only, W1C, W1S and R/W bits.
module inep_csr
    import inep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       room,
    input  logic       set_done,
    input  logic       set_urun,
    input  logic       set_ssent,
    input  logic       clr_short,
    output logic [7:0] rd_data,
    output logic       stall_force,
    output logic       short_arm,
    output logic       flush_req
);
    logic       done_q, urun_q, ssent_q, force_q, arm_q;
    logic [7:0] ones;

    assign ones = wr_en ? wr_data : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            urun_q  <= 1'b0;
            ssent_q <= 1'b0;
            force_q <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            // hardware set wins over a same-cycle software clear
            done_q  <= set_done  | (done_q  & ~ones[B_DONE]);
            urun_q  <= set_urun  | (urun_q  & ~ones[B_URUN]);
            ssent_q <= set_ssent | (ssent_q & ~ones[B_SSENT]);
            arm_q   <= ones[B_SHORT] | (arm_q & ~clr_short);
            if (wr_en) begin
                force_q <= wr_data[B_SFORCE];
            end
        end
    end

    always_comb begin
        rd_data           = 8'h00;
        rd_data[B_ROOM]   = room;
        rd_data[B_DONE]   = done_q;
        rd_data[B_URUN]   = urun_q;
        rd_data[B_SSENT]  = ssent_q;
        rd_data[B_SFORCE] = force_q;
        rd_data[B_SHORT]  = arm_q;
    end

    assign stall_force = force_q;
    assign short_arm   = arm_q;
    assign flush_req   = ones[B_FLUSH];
endmodule

// File: rtl/inep_fsm.sv
// Token / data / handshake sequencer.
module inep_fsm
    import inep_pkg::*;
#(
    parameter int MPS = 64,
    parameter int PW  = 8,
    parameter int LW  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          byte_req,
    input  logic          hs_valid,
    input  logic          hs_ack,
    input  logic          stall_force,
    input  logic          short_arm,
    input  logic [PW-1:0] unread,
    input  logic          fifo_empty,
    output logic          resp_valid,
    output hs_kind_e      resp_kind,
    output logic [LW-1:0] pkt_len,
    output logic          tx_last,
    output logic          sending,
    output logic          in_idle,
    output logic          in_wait,
    output logic          pop,
    output logic          underrun,
    output logic          commit,
    output logic          rewind,
    output logic          set_ssent,
    output logic          clr_short
);
    ep_state_e     state_q, state_d;
    logic [LW-1:0] len_q, len_d, rem_q, rem_d;
    logic          short_q, short_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            rem_q   <= '0;
            short_q <= 1'b0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
            rem_q   <= rem_d;
            short_q <= short_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        len_d   = len_q;
        rem_d   = rem_q;
        short_d = short_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_in) begin
                    if (stall_force) begin
                        state_d = ST_REPLY_STALL;
                    end else if (unread >= PW'(MPS)) begin
                        state_d = ST_REPLY_DATA;
                        len_d   = LW'(MPS);
                        short_d = 1'b0;
                    end else if (short_arm) begin
                        state_d = ST_REPLY_DATA;
                        len_d   = LW'(unread);
                        short_d = 1'b1;
                    end else begin
                        state_d = ST_REPLY_NAK;
                    end
                end
            end
            ST_REPLY_DATA: begin
                rem_d   = len_q;
                state_d = (len_q == '0) ? ST_WAIT_HS : ST_SEND;
            end
            ST_REPLY_NAK, ST_REPLY_STALL: begin
                state_d = ST_IDLE;
            end
            ST_SEND: begin
                if (byte_req) begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == LW'(1)) begin
                        state_d = ST_WAIT_HS;
                    end
                end
            end
            ST_WAIT_HS: begin
                if (hs_valid) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        resp_valid = 1'b0;
        resp_kind  = HS_NAK;
        sending    = 1'b0;
        in_idle    = 1'b0;
        in_wait    = 1'b0;
        set_ssent  = 1'b0;
        unique case (state_q)
            ST_IDLE:        in_idle = 1'b1;
            ST_REPLY_DATA:  begin resp_valid = 1'b1; resp_kind = HS_DATA;  end
            ST_REPLY_NAK:   begin resp_valid = 1'b1; resp_kind = HS_NAK;   end
            ST_REPLY_STALL: begin resp_valid = 1'b1; resp_kind = HS_STALL; set_ssent = 1'b1; end
            ST_SEND:        sending = 1'b1;
            ST_WAIT_HS:     in_wait = 1'b1;
            default:        in_idle = 1'b0;
        endcase
        pkt_len   = len_q;
        tx_last   = sending && (rem_q == LW'(1));
        pop       = sending && byte_req;
        underrun  = sending && byte_req && fifo_empty;
        commit    = in_wait && hs_valid && hs_ack;
        rewind    = in_wait && hs_valid && !hs_ack;
        clr_short = commit && short_q;
    end
endmodule

// File: rtl/bulk_in_ep.sv
module bulk_in_ep
    import inep_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int MPS   = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int LW   = $clog2(MPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [7:0]    csr_wdata,
    output logic [7:0]    csr_rdata,
    input  logic          fifo_we,
    input  logic [7:0]    fifo_wdata,
    input  logic          tok_in,
    output logic          resp_valid,
    output logic [1:0]    resp_kind,
    output logic [LW-1:0] pkt_len,
    input  logic          byte_req,
    output logic [7:0]    tx_byte,
    output logic          tx_last,
    input  logic          hs_valid,
    input  logic          hs_ack
);
    logic [7:0]    head;
    logic [PW-1:0] unread, stored;
    logic          fifo_empty, fifo_full, room;
    logic          stall_force, short_arm, flush_req;
    logic          sending, in_idle, in_wait, pop, underrun, commit, rewind;
    logic          set_ssent, clr_short;
    hs_kind_e      kind;

    assign room = (stored <= PW'(DEPTH - MPS));

    inep_fifo #(.DEPTH(DEPTH), .DW(8)) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(fifo_we), .push_data(fifo_wdata),
        .pop(pop), .flush(flush_req), .commit(commit), .rewind(rewind),
        .head(head), .unread(unread), .stored(stored),
        .empty(fifo_empty), .full(fifo_full)
    );

    inep_csr i_csr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(csr_we), .wr_data(csr_wdata), .room(room),
        .set_done(commit), .set_urun(underrun), .set_ssent(set_ssent),
        .clr_short(clr_short), .rd_data(csr_rdata),
        .stall_force(stall_force), .short_arm(short_arm), .flush_req(flush_req)
    );

    inep_fsm #(.MPS(MPS), .PW(PW), .LW(LW)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .tok_in(tok_in), .byte_req(byte_req),
        .hs_valid(hs_valid), .hs_ack(hs_ack),
        .stall_force(stall_force), .short_arm(short_arm),
        .unread(unread), .fifo_empty(fifo_empty),
        .resp_valid(resp_valid), .resp_kind(kind), .pkt_len(pkt_len),
        .tx_last(tx_last), .sending(sending), .in_idle(in_idle), .in_wait(in_wait),
        .pop(pop), .underrun(underrun), .commit(commit), .rewind(rewind),
        .set_ssent(set_ssent), .clr_short(clr_short)
    );

    assign resp_kind = kind;
    assign tx_byte   = (sending && !fifo_empty) ? head : 8'h00;
endmodule

// File: rtl/inep_checker.sv
module inep_checker
    import inep_pkg::*;
#(
    parameter int MPS = 64,
    parameter int PW  = 8,
    parameter int LW  = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          resp_valid,
    input logic [1:0]    resp_kind,
    input logic [LW-1:0] pkt_len,
    input logic [7:0]    csr_rdata,
    input logic          tok_in,
    input logic          byte_req,
    input logic          hs_valid,
    input logic          hs_ack,
    input logic          in_idle,
    input logic          in_wait,
    input logic          sending,
    input logic [PW-1:0] unread,
    input logic          flush_req
);
    a_r3_reply_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == HS_DATA) |-> (pkt_len <= LW'(MPS)));

    a_r6_stall_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == HS_STALL) |=> csr_rdata[B_SSENT]);

    a_r8_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && hs_valid && hs_ack) |=> csr_rdata[B_DONE]);

    a_r9_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && byte_req && unread == '0) |=> csr_rdata[B_URUN]);

    a_r10_flush_room: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> csr_rdata[B_ROOM]);

    a_r12_busy_token: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && !in_idle) |=> !resp_valid);
endmodule

bind bulk_in_ep inep_checker #(.MPS(MPS), .PW(PW), .LW(LW)) i_chk (
    .clk(clk), .rst_n(rst_n), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .pkt_len(pkt_len), .csr_rdata(csr_rdata), .tok_in(tok_in), .byte_req(byte_req),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .in_idle(in_idle), .in_wait(in_wait),
    .sending(sending), .unread(unread), .flush_req(flush_req)
);

// File: tb/test_bulk_in_ep.sv
`timescale 1ns/1ps
module test_bulk_in_ep;
    localparam int DEPTH = 128;
    localparam int MPS   = 64;
    localparam int LW    = $clog2(MPS + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, csr_we, fifo_we, tok_in, byte_req, hs_valid, hs_ack;
    logic [7:0]    csr_wdata, fifo_wdata, csr_rdata, tx_byte;
    logic          resp_valid, tx_last;
    logic [1:0]    resp_kind;
    logic [LW-1:0] pkt_len;

    bulk_in_ep #(.DEPTH(DEPTH), .MPS(MPS)) i_bulk_in_ep (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .tok_in(tok_in), .resp_valid(resp_valid), .resp_kind(resp_kind),
        .pkt_len(pkt_len), .byte_req(byte_req), .tx_byte(tx_byte),
        .tx_last(tx_last), .hs_valid(hs_valid), .hs_ack(hs_ack)
    );

    int vecs = 0, errs = 0;
    bit done_run = 0;
    logic [7:0] pv = 8'h00;

    // reference model: 0 idle, 1 reply data, 2 reply nak, 3 reply stall, 4 send, 5 wait
    logic [7:0] q[$];
    int ms = 0, sent = 0, mlen = 0, mrem = 0;
    bit mshort = 0, m_done = 0, m_ur = 0, m_ss = 0, m_sf = 0, m_sa = 0;

    task automatic check(string tag, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_csr();
        int v = 0;
        if ((DEPTH - q.size()) >= MPS) v |= 1;
        if (m_done) v |= 2;
        if (m_ur)   v |= 4;
        if (m_ss)   v |= 8;
        if (m_sf)   v |= 16;
        if (m_sa)   v |= 64;
        return v;
    endfunction

    task automatic compare();
        int un = q.size() - sent;
        int rv = (ms >= 1 && ms <= 3) ? 1 : 0;
        check("R2 csr", int'(csr_rdata), exp_csr());
        check("R3 resp_valid", int'(resp_valid), rv);
        if (rv == 1) begin
            check("R3 resp_kind", int'(resp_kind), (ms == 1) ? 1 : (ms == 3) ? 2 : 0);
            if (ms == 1) check("R3 pkt_len", int'(pkt_len), mlen);
        end
        check("R7 tx_byte", int'(tx_byte), (ms == 4 && un > 0) ? int'(q[sent]) : 0);
        check("R7 tx_last", int'(tx_last), (ms == 4 && mrem == 1) ? 1 : 0);
    endtask

    task automatic model_step();
        int un = q.size() - sent;
        bit full_old = (q.size() >= DEPTH);
        int nx = ms;
        bit sd = 0, su = 0, sss = 0, cs = 0;
        bit fl = csr_we && csr_wdata[5];
        case (ms)
            0: if (tok_in) begin
                   if (m_sf) nx = 3;
                   else if (un >= MPS) begin nx = 1; mlen = MPS; mshort = 0; end
                   else if (m_sa) begin nx = 1; mlen = un; mshort = 1; end
                   else nx = 2;
               end
            1: begin mrem = mlen; nx = (mlen == 0) ? 5 : 4; end
            2: nx = 0;
            3: begin sss = 1; nx = 0; end
            4: if (byte_req) begin
                   if (un == 0) su = 1;
                   else if (!fl) sent++;
                   if (mrem == 1) nx = 5;
                   mrem--;
               end
            5: if (hs_valid) begin
                   if (hs_ack) begin
                       for (int i = 0; i < sent; i++) void'(q.pop_front());
                       sd = 1;
                       cs = mshort;
                   end
                   sent = 0;
                   nx = 0;
               end
            default: nx = 0;
        endcase
        if (fl) begin
            q.delete();
            sent = 0;
        end else if (fifo_we && !full_old) begin
            q.push_back(fifo_wdata);
        end
        m_done = sd  | (m_done & !(csr_we & csr_wdata[1]));
        m_ur   = su  | (m_ur   & !(csr_we & csr_wdata[2]));
        m_ss   = sss | (m_ss   & !(csr_we & csr_wdata[3]));
        if (csr_we) m_sf = csr_wdata[4];
        m_sa = (csr_we & csr_wdata[6]) | (m_sa & !cs);
        ms = nx;
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        csr_we = 0; fifo_we = 0; tok_in = 0; byte_req = 0; hs_valid = 0; hs_ack = 0;
    endtask

    task automatic wr_csr(logic [7:0] v);
        csr_we = 1; csr_wdata = v; step();
    endtask

    task automatic push_n(int n);
        for (int i = 0; i < n; i++) begin
            fifo_we = 1; fifo_wdata = pv; step(); pv++;
        end
    endtask

    task automatic token();
        tok_in = 1; step();
    endtask

    task automatic stream(int n, bit with_tok);
        for (int i = 0; i < n; i++) begin
            byte_req = 1; tok_in = with_tok; step();
            if (with_tok) check("R12 no reply while busy", int'(resp_valid), 0);
        end
    endtask

    task automatic handshake(bit ack);
        hs_valid = 1; hs_ack = ack; step();
    endtask

    initial begin
        #(200000 * 5);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        rst_n = 0; csr_we = 0; csr_wdata = 0; fifo_we = 0; fifo_wdata = 0;
        tok_in = 0; byte_req = 0; hs_valid = 0; hs_ack = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        compare();
        check("R1 csr reset", int'(csr_rdata), 8'h01);
        check("R1 no reply", int'(resp_valid), 0);

        // NAK with nothing stored, then with a partial packet
        token();
        check("R5 nak empty", int'({resp_valid, resp_kind}), 3'b100);
        step();
        push_n(10);
        token();
        check("R5 nak partial", int'({resp_valid, resp_kind}), 3'b100);
        step();

        // short packet of 10 bytes
        wr_csr(8'h40);
        check("R4 armed", int'(csr_rdata[6]), 1);
        token();
        check("R4 short kind", int'(resp_kind), 1);
        check("R4 short len", int'(pkt_len), 10);
        step();
        check("R7 first byte", int'(tx_byte), 0);
        stream(10, 0);
        handshake(1);
        check("R8 sent-ok set", int'(csr_rdata[1]), 1);
        check("R4 arm cleared", int'(csr_rdata[6]), 0);
        wr_csr(8'h02);
        check("R8 sent-ok w1c", int'(csr_rdata[1]), 0);

        // full packet, refused, resent
        push_n(70);
        check("R10 room low", int'(csr_rdata[0]), 0);
        token();
        check("R3 full len", int'(pkt_len), 64);
        step();
        stream(63, 0);
        check("R7 last flag", int'(tx_last), 1);
        stream(1, 0);
        handshake(0);
        token();
        step();
        check("R8 resend first", int'(tx_byte), 10);
        stream(64, 0);
        handshake(1);
        check("R10 room back", int'(csr_rdata[0]), 1);
        token();
        check("R5 nak leftover", int'(resp_kind), 0);
        step();

        // zero-length packet
        wr_csr(8'h20);
        check("R10 flushed room", int'(csr_rdata[0]), 1);
        wr_csr(8'h40);
        token();
        check("R4 zero len", int'(pkt_len), 0);
        step();
        handshake(1);
        check("R4 zero arm cleared", int'(csr_rdata[6]), 0);

        // forced STALL beats a stored full packet
        wr_csr(8'h10);
        push_n(64);
        token();
        check("R6 stall kind", int'(resp_kind), 2);
        step();
        check("R6 stall sent", int'(csr_rdata[3]), 1);
        wr_csr(8'h18);
        check("R6 w1c keeps force", int'(csr_rdata[4:3]), 2'b10);
        wr_csr(8'h00);

        // underrun by flushing mid-packet; tokens while busy
        token();
        step();
        stream(3, 1);
        wr_csr(8'h20);
        stream(1, 0);
        check("R9 underrun flag", int'(csr_rdata[2]), 1);
        check("R9 zero byte", int'(tx_byte), 0);
        stream(60, 0);
        handshake(0);
        wr_csr(8'h04);
        check("R9 underrun w1c", int'(csr_rdata[2]), 0);

        // overfill: 130 written, 128 kept
        push_n(130);
        check("R11 room full", int'(csr_rdata[0]), 0);
        for (int k = 0; k < 2; k++) begin
            token();
            step();
            stream(64, 0);
            handshake(1);
        end
        token();
        check("R11 dropped bytes", int'(resp_kind), 0);
        step();

        // unused bits and read-only room
        wr_csr(8'hA0);
        check("R2 bits 5 and 7 zero", int'({csr_rdata[7], csr_rdata[5]}), 0);
        push_n(70);
        wr_csr(8'h01);
        check("R2 room read-only", int'(csr_rdata[0]), 0);

        done_run = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule